// File: doc/BRIEF.md
# Stereo Serial Audio Deserialiser

This block sits directly on a three-wire stereo audio link and runs on the link's bit clock. Each rising bit-clock edge samples the word-select line and the serial data line. The block finds the start of every channel slot and collects each slot's bits most-significant first. When a left/right pair is complete, it presents the pair as two 32-bit two's-complement words, sign-extended from the received word length.

A static mode input chooses between two framings. The first is the classic inter-IC-sound framing: the left channel is carried while word-select is low, and the data lags word-select by one bit clock. The second is the left-justified framing: the left channel is carried while word-select is high, and there is no lag. The block needs no word-length setting. It counts the bit clocks between two left-slot starts and picks 16, 24 or 32 bits for a frame of 32, 48 or 64 clocks. Any other frame length raises an error level instead of producing data.

The output side is a bare valid strobe. The serial link cannot be paused, so there is no ready input and no back-pressure. A consumer must take each pair in the cycle in which `pcm_valid` is high, or lose it.

Top module: `stereo_serial_rx`

## Requirements
- R1: With `mode_lj` low, the left slot is the period in which `ws` is low and the right slot the period in which it is high; the MSB of a slot is sampled on the second rising clock edge after the `ws` change.
- R2: With `mode_lj` high, the left slot is the period in which `ws` is high and the right slot the period in which it is low; the MSB of a slot is sampled on the first rising clock edge after the `ws` change.
- R3: Words arrive MSB first in two's complement and appear on `pcm_left`/`pcm_right` sign-extended to 32 bits.
- R4: A frame of 32 clocks (left start to next left start) is decoded as 16-bit words, reported with `pcm_wlen` = 0.
- R5: A frame of 48 clocks is decoded as 24-bit words, reported with `pcm_wlen` = 1.
- R6: A frame of 64 clocks is decoded as 32-bit words, reported with `pcm_wlen` = 2.
- R7: A frame of any other length sets `frame_err` high and produces no `pcm_valid`. The next frame of legal length clears `frame_err`.
- R8: Each legal frame yields exactly one single-cycle `pcm_valid`, issued when the following left slot starts, so that the right slot is complete. Nothing is issued before the first left-slot start after reset.
- R9: While reset is active and directly after it, `pcm_valid` and `frame_err` are low and both sample words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_lj | input | 1 | Framing select: 0 delayed-MSB framing, 1 left-justified |
| ws | input | 1 | Word-select (channel) line |
| sdata | input | 1 | Serial data line |
| pcm_valid | output | 1 | One-cycle strobe marking a new stereo pair |
| pcm_left | output | 32 | Left sample, sign-extended |
| pcm_right | output | 32 | Right sample, sign-extended |
| pcm_wlen | output | 2 | Decoded word length: 0=16, 1=24, 2=32 |
| frame_err | output | 1 | High while the last measured frame had an illegal length |

## Verification
On every cycle, the embedded properties check four things. A valid strobe never lasts two cycles. It never coincides with the error level. Sample words reported at 16 or 24 bits carry clean sign-extension in their upper bits. Each slot start restarts the bit position. Only the bench's scenarios can show that the right bits land in the right channel under each framing, including the one-clock lag and the carry of a right-slot LSB into the next frame. The same applies to whether the frame length is classified correctly across a changing stream, and whether an illegal frame is reported once and then cleared.

// File: rtl/stereo_serial_rx_pkg.sv
package stereo_serial_rx_pkg;

  localparam int unsigned SAMPLE_W = 32;

  typedef enum logic [1:0] {
    WL_16 = 2'd0,
    WL_24 = 2'd1,
    WL_32 = 2'd2
  } wlen_e;

  // Turn an MSB-aligned capture into a right-aligned, sign-extended sample.
  function automatic logic [SAMPLE_W-1:0] sign_fill(input logic [SAMPLE_W-1:0] raw,
                                                    input wlen_e wl);
    logic [SAMPLE_W-1:0] res;
    case (wl)
      WL_16:   res = {{16{raw[SAMPLE_W-1]}}, raw[SAMPLE_W-1 -: 16]};
      WL_24:   res = {{8{raw[SAMPLE_W-1]}},  raw[SAMPLE_W-1 -: 24]};
      default: res = raw;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/ssr_slot_framer.sv
// Finds slot boundaries on the word-select line and names the channel.
module ssr_slot_framer (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_lj,
  input  logic ws,
  output logic slot_start,
  output logic slot_left
);
  logic armed;
  logic ws_q;
  logic ws_edge;
  logic ws_edge_q;

  // No edge is taken on the first sampled cycle after reset.
  assign ws_edge = armed && (ws != ws_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      ws_q      <= 1'b0;
      ws_edge_q <= 1'b0;
    end else begin
      armed     <= 1'b1;
      ws_q      <= ws;
      ws_edge_q <= ws_edge;
    end
  end

  // Left-justified: the slot opens with the edge itself, left while high.
  // Delayed framing: the slot opens one clock later, left while low.
  assign slot_start = mode_lj ? ws_edge : ws_edge_q;
  assign slot_left  = mode_lj ? ws      : ~ws_q;

endmodule

// File: rtl/ssr_frame_meter.sv
// Measures clocks between left-slot starts and decodes the word length.
module ssr_frame_meter
  import stereo_serial_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot_start,
  input  logic  slot_left,
  output logic  frame_done,
  output logic  frame_ok,
  output wlen_e frame_wl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LEN_32  = CNT_W'(32);
  localparam logic [CNT_W-1:0] LEN_48  = CNT_W'(48);
  localparam logic [CNT_W-1:0] LEN_64  = CNT_W'(64);

  logic [CNT_W-1:0] clk_cnt;
  logic             primed;
  logic             right_seen;
  logic             left_start;

  assign left_start = slot_start && slot_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_cnt    <= '0;
      primed     <= 1'b0;
      right_seen <= 1'b0;
    end else begin
      if (left_start) begin
        clk_cnt    <= CNT_W'(1);
        primed     <= 1'b1;
        right_seen <= 1'b0;
      end else begin
        if (clk_cnt != CNT_MAX) clk_cnt <= clk_cnt + 1'b1;
        if (slot_start) right_seen <= 1'b1;
      end
    end
  end

  // A frame closes at a left start that follows a full left and right slot.
  assign frame_done = left_start && primed && right_seen;

  always_comb begin
    frame_ok = 1'b1;
    frame_wl = WL_32;
    if (clk_cnt == LEN_32)      frame_wl = WL_16;
    else if (clk_cnt == LEN_48) frame_wl = WL_24;
    else if (clk_cnt == LEN_64) frame_wl = WL_32;
    else                        frame_ok = 1'b0;
  end

endmodule

// File: rtl/ssr_slot_capture.sv
// Collects the bits of each slot MSB-aligned; bits past the width are dropped.
module ssr_slot_capture
  import stereo_serial_rx_pkg::*;
#(
  parameter int unsigned SLOT_W = SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic              slot_left,
  input  logic              sdata,
  output logic [SLOT_W-1:0] left_word,
  output logic [SLOT_W-1:0] cur_word
);
  localparam int unsigned POS_W = $clog2(SLOT_W) + 1;
  localparam int unsigned IDX_W = $clog2(SLOT_W);
  localparam logic [POS_W-1:0] POS_END = POS_W'(SLOT_W);

  logic [SLOT_W-1:0] shreg;
  logic [SLOT_W-1:0] left_hold;
  logic [POS_W-1:0]  pos;
  logic              cur_left;
  logic [IDX_W-1:0]  bit_idx;

  assign bit_idx = IDX_W'(SLOT_W - 1) - pos[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      left_hold <= '0;
      pos       <= POS_END;
      cur_left  <= 1'b0;
    end else if (slot_start) begin
      if (cur_left) left_hold <= shreg;
      shreg    <= {sdata, {(SLOT_W-1){1'b0}}};
      pos      <= POS_W'(1);
      cur_left <= slot_left;
    end else if (pos != POS_END) begin
      shreg[bit_idx] <= sdata;
      pos            <= pos + 1'b1;
    end
  end

  assign left_word = left_hold;
  assign cur_word  = shreg;

  // R1 R2: every slot start puts the next bit at the second position
  assert_slot_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> (pos == POS_W'(1)));

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import stereo_serial_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_lj,
  input  logic                ws,
  input  logic                sdata,
  output logic                pcm_valid,
  output logic [SAMPLE_W-1:0] pcm_left,
  output logic [SAMPLE_W-1:0] pcm_right,
  output logic [1:0]          pcm_wlen,
  output logic                frame_err
);
  logic                slot_start;
  logic                slot_left;
  logic                frame_done;
  logic                frame_ok;
  wlen_e               frame_wl;
  logic [SAMPLE_W-1:0] left_word;
  logic [SAMPLE_W-1:0] cur_word;

  ssr_slot_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_lj    (mode_lj),
    .ws         (ws),
    .slot_start (slot_start),
    .slot_left  (slot_left)
  );

  ssr_frame_meter #(.CNT_W(CNT_W)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .slot_left  (slot_left),
    .frame_done (frame_done),
    .frame_ok   (frame_ok),
    .frame_wl   (frame_wl)
  );

  ssr_slot_capture #(.SLOT_W(SAMPLE_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .slot_left  (slot_left),
    .sdata      (sdata),
    .left_word  (left_word),
    .cur_word   (cur_word)
  );

  // When a frame closes, the word still being shifted is the finished right slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcm_valid <= 1'b0;
      pcm_left  <= '0;
      pcm_right <= '0;
      pcm_wlen  <= WL_16;
      frame_err <= 1'b0;
    end else begin
      pcm_valid <= frame_done && frame_ok;
      if (frame_done) frame_err <= !frame_ok;
      if (frame_done && frame_ok) begin
        pcm_left  <= sign_fill(left_word, frame_wl);
        pcm_right <= sign_fill(cur_word, frame_wl);
        pcm_wlen  <= frame_wl;
      end
    end
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);

  assert_err_blocks_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |-> !frame_err);

  assert_sext16_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && pcm_wlen == WL_16) |->
      (pcm_left[31:16] == {16{pcm_left[15]}} && pcm_right[31:16] == {16{pcm_right[15]}}));

  assert_sext24_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && pcm_wlen == WL_24) |->
      (pcm_left[31:24] == {8{pcm_left[23]}} && pcm_right[31:24] == {8{pcm_right[23]}}));

endmodule

// File: tb/tb_stereo_serial_rx.sv
module tb_stereo_serial_rx;

  typedef struct packed {
    logic [31:0] l;
    logic [31:0] r;
    logic [1:0]  wl;
  } pair_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_lj = 1'b0;
  logic        ws = 1'b0;
  logic        sdata = 1'b0;
  logic        pcm_valid;
  logic [31:0] pcm_left;
  logic [31:0] pcm_right;
  logic [1:0]  pcm_wlen;
  logic        frame_err;

  int    n_checks = 0;
  int    n_errors = 0;
  int    err_rises = 0;
  logic  err_prev = 1'b0;
  logic  carry = 1'b0;
  logic  done = 1'b0;
  pair_t expq[$];

  always #2.5 clk = ~clk;

  stereo_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .mode_lj(mode_lj), .ws(ws), .sdata(sdata),
    .pcm_valid(pcm_valid), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .pcm_wlen(pcm_wlen), .frame_err(frame_err)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [31:0] v, input int b);
    logic [31:0] t;
    t = v << (32 - b);
    return 32'($signed(t) >>> (32 - b));
  endfunction

  // Monitor: compares each strobe with the head of the expectation queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_err && !err_prev) err_rises++;
      err_prev = frame_err;
      if (pcm_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R8 unexpected strobe", 32'(pcm_valid), 32'd0);
        end else begin
          pair_t e;
          e = expq.pop_front();
          chk(pcm_left == e.l, "R1 R2 R3 left", pcm_left, e.l);
          chk(pcm_right == e.r, "R1 R2 R3 right", pcm_right, e.r);
          chk(pcm_wlen == e.wl, "R4 R5 R6 length code", 32'(pcm_wlen), 32'(e.wl));
        end
      end
    end
  end

  task automatic drive_slot(input logic lv, input int b, input logic [31:0] w);
    for (int p = 0; p < b; p++) begin
      @(negedge clk);
      ws = lv;
      if (mode_lj) sdata = w[b-1-p];
      else         sdata = (p == 0) ? carry : w[b-p];
    end
    carry = w[0];
  endtask

  // Driver: sends one frame and, if it will be reported, queues the result.
  task automatic send_frame(input int b, input logic [31:0] l, input logic [31:0] r,
                            input logic expect_it);
    pair_t e;
    drive_slot(mode_lj ? 1'b1 : 1'b0, b, l);
    drive_slot(mode_lj ? 1'b0 : 1'b1, b, r);
    if (expect_it) begin
      e.l  = sext(l, b);
      e.r  = sext(r, b);
      e.wl = (b == 16) ? 2'd0 : (b == 24) ? 2'd1 : 2'd2;
      expq.push_back(e);
    end
  endtask

  task automatic start_mode(input logic lj, input logic first);
    @(negedge clk);
    rst_n = 1'b0;
    mode_lj = lj;
    ws = lj ? 1'b0 : 1'b1;   // idle in the right-slot level
    sdata = 1'b0;
    carry = 1'b0;
    repeat (3) @(negedge clk);
    if (first) begin
      chk(pcm_valid == 1'b0, "R9 valid in reset", 32'(pcm_valid), 32'd0);
      chk(frame_err == 1'b0, "R9 error in reset", 32'(frame_err), 32'd0);
      chk(pcm_left == 32'd0 && pcm_right == 32'd0, "R9 words in reset", pcm_left, 32'd0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic flush();
    send_frame(16, 32'h0, 32'h0, 1'b0);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R8 pending pairs", 32'(expq.size()), 32'd0);
  endtask

  initial begin
    // Delayed-MSB framing
    start_mode(1'b0, 1'b1);
    send_frame(16, 32'h8000, 32'h7FFF, 1'b1);
    send_frame(16, 32'h1234, 32'hFEDC, 1'b1);
    send_frame(24, 32'h800001, 32'h7FFFFE, 1'b1);
    send_frame(32, 32'h80000000, 32'hDEADBEEF, 1'b1);
    send_frame(32, 32'h00000001, 32'hFFFFFFFF, 1'b1);
    send_frame(24, 32'hA5A5A5, 32'h0F0F0F, 1'b1);
    flush();

    // Left-justified framing
    start_mode(1'b1, 1'b0);
    send_frame(16, 32'hC001, 32'h4002, 1'b1);
    send_frame(24, 32'hFFFFFF, 32'h123456, 1'b1);
    send_frame(32, 32'h7FFFFFFF, 32'h89ABCDEF, 1'b1);
    send_frame(16, 32'hFFFF, 32'h0001, 1'b1);
    flush();
    chk(err_rises == 0, "R7 no error on legal frames", 32'(err_rises), 32'd0);

    // Illegal frame length in the middle of a stream
    start_mode(1'b1, 1'b0);
    send_frame(24, 32'h654321, 32'h9ABCDE, 1'b1);
    send_frame(20, 32'h12345, 32'h54321, 1'b0);
    send_frame(16, 32'h2468, 32'h8ACE, 1'b1);
    chk(frame_err == 1'b1, "R7 error level after bad frame", 32'(frame_err), 32'd1);
    flush();
    chk(err_rises == 1, "R7 single error report", 32'(err_rises), 32'd1);
    chk(frame_err == 1'b0, "R7 error cleared by legal frame", 32'(frame_err), 32'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) chk(1'b0, "R8 watchdog expired", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule